// File: doc/BRIEF.md
# Transfer Descriptor Execution Engine

This engine takes one transfer descriptor, given as a 32-bit control word and a 32-bit token word, and carries it through a single bus transaction. It pulls the packet identifier, device address, endpoint and byte limit out of the token and presents them on a request/response transaction port. It then classifies the answer and produces the rewritten control word, a two-bit completion code and a three-bit interrupt-cause mask. A descriptor walker around the engine fetches the descriptor, starts the engine, writes the returned control word back to memory and uses the completion code to decide where the list walk goes next.

A transaction may answer "deferred" instead of giving a result. In that case the engine reports the pending code, leaves the descriptor untouched and marks one transaction as outstanding. The result arrives later on a separate completion port and is held. When the walker starts the engine again with the resume flag set, the held result is applied to the descriptor as though it had just arrived. While a transaction is outstanding, no other descriptor can start a new one.

Top module: `xd_engine`

## Requirements
- R1: The bus request carries the packet identifier from token[7:0], the device address from token[14:8], the endpoint from token[18:15], the data toggle from token[19], and the byte limit ((token[31:21] + 1) mod 2048), so that a field of 0x7FF means zero bytes.
- R2: Whenever control bit 24 (interrupt on complete) is set, bit 0 of the interrupt mask is set in the result. This holds for every completion code, inactive descriptors included.
- R3: A descriptor with control bit 23 (active) clear finishes with code 1, returns the control word unchanged and raises no bus request.
- R4: An active descriptor whose identifier is not SETUP (0x2D), IN (0x69) or OUT (0xE1) finishes with code 3 (fatal), pulses the process-error output together with done, returns the control word unchanged and raises no bus request.
- R5: A successful transaction (response kind 0) finishes with code 0. Control[10:0] receives (length - 1) mod 2048, and active (bit 23) and the stale NAK flag (bit 19) are cleared. For OUT and SETUP the length is the byte limit, and for IN it is the returned length.
- R6: An IN answer longer than the byte limit is treated as babble: bits 20 and 22 are set, active is cleared, control[10:0] is kept and the code is 1.
- R7: A successful IN with control bit 29 (short packet detect) set and a length below the byte limit sets bit 1 of the interrupt mask.
- R8: A NAK answer (kind 1) sets control bit 19, keeps active set and finishes with code 1.
- R9: A stall answer (kind 2) sets control bit 22, clears active and finishes with code 1.
- R10: A fault answer (kind 3) sets control bit 18. If the error counter in control[28:27] is non-zero, it is decremented, and when it reaches zero active is cleared and interrupt-mask bit 2 is set. A counter of zero is left alone and active stays set. The code is 1.
- R11: A deferred answer (kind 4) finishes with code 2, leaves the control word unchanged and sets the outstanding output.
- R12: While a transaction is outstanding, no bus request is raised. Any active, well-formed descriptor started without a usable held result finishes with code 2 and an unchanged control word.
- R13: A resume start after the completion port has delivered a result applies that held result under R5 to R10 and clears outstanding. A resume start before any completion arrives finishes with code 2.
- R14: Start is accepted only while ready is high. The bus request, with its fields, holds until a response is accepted. Done is a single-cycle pulse, and the result outputs hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing the presented descriptor |
| resume | input | 1 | Apply the held deferred result instead of issuing |
| ctrl_in | input | 32 | Descriptor control word |
| token_in | input | 32 | Descriptor token word |
| ready | output | 1 | Engine idle, start accepted |
| done | output | 1 | One-cycle pulse, result outputs valid |
| res_code | output | 2 | 0 success, 1 inactive/failed, 2 pending, 3 fatal |
| ctrl_out | output | 32 | Rewritten control word |
| int_mask | output | 3 | bit0 complete, bit1 short packet, bit2 error limit |
| hc_perr | output | 1 | Process error, pulses with done on fatal |
| outstanding | output | 1 | A deferred transaction is in flight |
| bus_req | output | 1 | Transaction request |
| bus_pid | output | 8 | Packet identifier |
| bus_dev | output | 7 | Device address |
| bus_ep | output | 4 | Endpoint |
| bus_toggle | output | 1 | Data toggle |
| bus_len | output | 11 | Byte limit |
| bus_rsp_valid | input | 1 | Response accepted this cycle |
| bus_rsp_kind | input | 3 | 0 ack, 1 NAK, 2 stall, 3 fault, 4 deferred |
| bus_rsp_len | input | 12 | Returned byte count for IN |
| bus_cpl_valid | input | 1 | Late completion of the deferred transaction |
| bus_cpl_kind | input | 3 | Late completion kind, encoded as bus_rsp_kind |
| bus_cpl_len | input | 12 | Late completion byte count |

## Verification
The hardest situation to reach is the deferred path. A transaction has to be left outstanding, then other descriptors have to hit the engine without raising a request, then a resume start has to arrive before the late completion and another after it. The bench reaches it with one task that answers a request with the deferred kind. It then starts an unrelated OUT descriptor and a premature resume, both of which must return the pending code with no request seen. Only after that does it pulse the completion port and resume the original IN descriptor, whose rewritten control word has to reflect the held length.

// File: rtl/xd_pkg.sv
package xd_pkg;
  localparam int CTRL_W  = 32;
  localparam int ALEN_W  = 11;

  // control word bit positions (decoded by the list walker)
  localparam int B_TMO    = 18;
  localparam int B_NAK    = 19;
  localparam int B_BABBLE = 20;
  localparam int B_STALL  = 22;
  localparam int B_ACTIVE = 23;
  localparam int B_IOC    = 24;
  localparam int B_ERR_LO = 27;
  localparam int B_ERR_HI = 28;
  localparam int B_SPD    = 29;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  localparam logic [1:0] XC_OK   = 2'd0;
  localparam logic [1:0] XC_SKIP = 2'd1;
  localparam logic [1:0] XC_WAIT = 2'd2;
  localparam logic [1:0] XC_HALT = 2'd3;

  localparam logic [2:0] BR_ACK   = 3'd0;
  localparam logic [2:0] BR_NAK   = 3'd1;
  localparam logic [2:0] BR_STALL = 3'd2;
  localparam logic [2:0] BR_FAULT = 3'd3;
  localparam logic [2:0] BR_DEFER = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_FIN} xd_state_e;

  // byte limit: field + 1, wrapping so that all-ones means zero bytes
  function automatic logic [ALEN_W-1:0] limit_of(input logic [ALEN_W-1:0] fld);
    return fld + ALEN_W'(1);
  endfunction

  // actual-length field written back: count - 1, wrapping
  function automatic logic [ALEN_W-1:0] actlen_of(input logic [ALEN_W-1:0] n);
    return n - ALEN_W'(1);
  endfunction
endpackage

// File: rtl/xd_decode.sv
module xd_decode
  import xd_pkg::*;
(
  input  logic [31:0]       token,
  output logic [7:0]        pid,
  output logic [6:0]        dev,
  output logic [3:0]        ep,
  output logic              toggle,
  output logic [ALEN_W-1:0] max_len,
  output logic              pid_ok,
  output logic              pid_is_in
);
  assign pid       = token[7:0];
  assign dev       = token[14:8];
  assign ep        = token[18:15];
  assign toggle    = token[19];
  assign max_len   = limit_of(token[31:21]);
  assign pid_is_in = (pid == PID_IN);
  assign pid_ok    = pid_is_in || (pid == PID_OUT) || (pid == PID_SETUP);
endmodule

// File: rtl/xd_eval.sv
module xd_eval
  import xd_pkg::*;
#(
  parameter int RLEN_W = 12
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              is_in,
  input  logic [ALEN_W-1:0] max_len,
  input  logic [2:0]        kind,
  input  logic [RLEN_W-1:0] rlen,
  output logic [CTRL_W-1:0] ctrl_new,
  output logic [1:0]        code,
  output logic              short_hit,
  output logic              err_limit
);
  logic [RLEN_W-1:0] max_ext;
  logic [RLEN_W-1:0] len_eff;
  logic              babble;
  logic [1:0]        err_cnt;
  logic [1:0]        err_dec;

  assign max_ext = RLEN_W'(max_len);
  assign babble  = is_in && (rlen > max_ext);
  assign len_eff = is_in ? rlen : max_ext;
  assign err_cnt = ctrl[B_ERR_HI:B_ERR_LO];
  assign err_dec = err_cnt - 2'd1;

  always_comb begin
    ctrl_new  = ctrl;
    code      = XC_SKIP;
    short_hit = 1'b0;
    err_limit = 1'b0;
    case (kind)
      BR_ACK: begin
        if (babble) begin
          ctrl_new[B_BABBLE] = 1'b1;
          ctrl_new[B_STALL]  = 1'b1;
          ctrl_new[B_ACTIVE] = 1'b0;
        end else begin
          ctrl_new[ALEN_W-1:0] = actlen_of(len_eff[ALEN_W-1:0]);
          ctrl_new[B_ACTIVE]   = 1'b0;
          ctrl_new[B_NAK]      = 1'b0;
          code                 = XC_OK;
          short_hit            = is_in && ctrl[B_SPD] && (len_eff < max_ext);
        end
      end
      BR_NAK: ctrl_new[B_NAK] = 1'b1;
      BR_STALL: begin
        ctrl_new[B_STALL]  = 1'b1;
        ctrl_new[B_ACTIVE] = 1'b0;
      end
      default: begin
        ctrl_new[B_TMO] = 1'b1;
        if (err_cnt != 2'd0) begin
          ctrl_new[B_ERR_HI:B_ERR_LO] = err_dec;
          if (err_dec == 2'd0) begin
            ctrl_new[B_ACTIVE] = 1'b0;
            err_limit          = 1'b1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/xd_hold.sv
module xd_hold #(
  parameter int RLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              consume_i,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_kind,
  input  logic [RLEN_W-1:0] cpl_len,
  output logic              busy_o,
  output logic              have_o,
  output logic [2:0]        kind_o,
  output logic [RLEN_W-1:0] len_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      have_o <= 1'b0;
      kind_o <= '0;
      len_o  <= '0;
    end else if (consume_i) begin
      busy_o <= 1'b0;
      have_o <= 1'b0;
    end else if (open_i) begin
      busy_o <= 1'b1;
      have_o <= 1'b0;
    end else if (cpl_valid && busy_o && !have_o) begin
      have_o <= 1'b1;
      kind_o <= cpl_kind;
      len_o  <= cpl_len;
    end
  end
endmodule

// File: rtl/xd_engine.sv
module xd_engine
  import xd_pkg::*;
#(
  parameter int RLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resume,
  input  logic [31:0]       ctrl_in,
  input  logic [31:0]       token_in,
  output logic              ready,
  output logic              done,
  output logic [1:0]        res_code,
  output logic [31:0]       ctrl_out,
  output logic [2:0]        int_mask,
  output logic              hc_perr,
  output logic              outstanding,
  output logic              bus_req,
  output logic [7:0]        bus_pid,
  output logic [6:0]        bus_dev,
  output logic [3:0]        bus_ep,
  output logic              bus_toggle,
  output logic [10:0]       bus_len,
  input  logic              bus_rsp_valid,
  input  logic [2:0]        bus_rsp_kind,
  input  logic [RLEN_W-1:0] bus_rsp_len,
  input  logic              bus_cpl_valid,
  input  logic [2:0]        bus_cpl_kind,
  input  logic [RLEN_W-1:0] bus_cpl_len
);
  xd_state_e         st;
  logic [CTRL_W-1:0] ctrl_q;
  logic [31:0]       tok_q;
  logic              resume_q;
  logic              perr_q;
  logic [CTRL_W-1:0] res_ctrl;
  logic [1:0]        res_code_q;
  logic [2:0]        res_mask;

  logic              pid_ok, pid_is_in;
  logic [ALEN_W-1:0] max_len;
  logic              have;
  logic [2:0]        held_kind;
  logic [RLEN_W-1:0] held_len;
  logic [2:0]        ev_kind;
  logic [RLEN_W-1:0] ev_len;
  logic [CTRL_W-1:0] ev_ctrl;
  logic [1:0]        ev_code;
  logic              ev_short, ev_exh;

  // named internal events
  logic ioc, ev_skip, ev_fatal, ev_consume, ev_defer, ev_block;

  xd_decode u_dec (
    .token(tok_q), .pid(bus_pid), .dev(bus_dev), .ep(bus_ep),
    .toggle(bus_toggle), .max_len(max_len), .pid_ok(pid_ok), .pid_is_in(pid_is_in)
  );

  assign bus_len = max_len;
  assign ioc     = ctrl_q[B_IOC];

  assign ev_skip    = (st == S_CHECK) && !ctrl_q[B_ACTIVE];
  assign ev_fatal   = (st == S_CHECK) && ctrl_q[B_ACTIVE] && !pid_ok;
  assign ev_consume = (st == S_CHECK) && ctrl_q[B_ACTIVE] && pid_ok && resume_q && have;
  assign ev_block   = (st == S_CHECK) && ctrl_q[B_ACTIVE] && pid_ok && !ev_consume && outstanding;
  assign ev_defer   = (st == S_ISSUE) && bus_rsp_valid && (bus_rsp_kind == BR_DEFER);

  xd_hold #(.RLEN_W(RLEN_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .open_i(ev_defer), .consume_i(ev_consume),
    .cpl_valid(bus_cpl_valid), .cpl_kind(bus_cpl_kind), .cpl_len(bus_cpl_len),
    .busy_o(outstanding), .have_o(have), .kind_o(held_kind), .len_o(held_len)
  );

  assign ev_kind = (st == S_ISSUE) ? bus_rsp_kind : held_kind;
  assign ev_len  = (st == S_ISSUE) ? bus_rsp_len  : held_len;

  xd_eval #(.RLEN_W(RLEN_W)) u_eval (
    .ctrl(ctrl_q), .is_in(pid_is_in), .max_len(max_len), .kind(ev_kind), .rlen(ev_len),
    .ctrl_new(ev_ctrl), .code(ev_code), .short_hit(ev_short), .err_limit(ev_exh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ctrl_q     <= '0;
      tok_q      <= '0;
      resume_q   <= 1'b0;
      perr_q     <= 1'b0;
      res_ctrl   <= '0;
      res_code_q <= XC_OK;
      res_mask   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ctrl_q   <= ctrl_in;
          tok_q    <= token_in;
          resume_q <= resume;
          perr_q   <= 1'b0;
          st       <= S_CHECK;
        end
        S_CHECK: begin
          if (ev_skip || ev_fatal || ev_block) begin
            res_ctrl   <= ctrl_q;
            res_code_q <= ev_skip ? XC_SKIP : (ev_fatal ? XC_HALT : XC_WAIT);
            res_mask   <= {2'b00, ioc};
            perr_q     <= ev_fatal;
            st         <= S_FIN;
          end else if (ev_consume) begin
            res_ctrl   <= ev_ctrl;
            res_code_q <= ev_code;
            res_mask   <= {ev_exh, ev_short, ioc};
            st         <= S_FIN;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: if (bus_rsp_valid) begin
          if (ev_defer) begin
            res_ctrl   <= ctrl_q;
            res_code_q <= XC_WAIT;
            res_mask   <= {2'b00, ioc};
          end else begin
            res_ctrl   <= ev_ctrl;
            res_code_q <= ev_code;
            res_mask   <= {ev_exh, ev_short, ioc};
          end
          st <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready    = (st == S_IDLE);
  assign done     = (st == S_FIN);
  assign bus_req  = (st == S_ISSUE);
  assign res_code = res_code_q;
  assign ctrl_out = res_ctrl;
  assign int_mask = res_mask;
  assign hc_perr  = done && perr_q;
endmodule

// File: rtl/xd_engine_chk.sv
module xd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        ready,
  input logic [31:0] ctrl_in,
  input logic        done,
  input logic [1:0]  res_code,
  input logic [31:0] ctrl_out,
  input logic [2:0]  int_mask,
  input logic        hc_perr,
  input logic        outstanding,
  input logic        bus_req,
  input logic        bus_rsp_valid,
  input logic [7:0]  bus_pid
);
  logic [31:0] cap_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_ctrl <= '0;
    else if (start && ready) cap_ctrl <= ctrl_in;
  end

  assert_inactive_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_ctrl[23]) |-> (res_code == 2'd1 && ctrl_out == cap_ctrl));

  assert_ioc_reported_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_ctrl[24]) |-> int_mask[0]);

  assert_perr_fatal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hc_perr |-> (done && res_code == 2'd3 && ctrl_out == cap_ctrl));

  assert_success_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_code == 2'd0) |-> (!ctrl_out[23] && !ctrl_out[19]));

  assert_short_on_success_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int_mask[1]) |-> (res_code == 2'd0));

  assert_err_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int_mask[2]) |-> (res_code == 2'd1 && !ctrl_out[23] && ctrl_out[28:27] == 2'd0));

  assert_pending_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_code == 2'd2) |-> (ctrl_out == cap_ctrl));

  assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !bus_req);

  assert_req_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rsp_valid) |=> (bus_req && $stable(bus_pid)));

  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind xd_engine xd_engine_chk u_chk (.*);

// File: tb/xd_engine_test.sv
`timescale 1ns/1ps
module xd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, resume = 1'b0;
  logic [31:0] ctrl_in = '0, token_in = '0;
  logic        ready, done, hc_perr, outstanding, bus_req, bus_toggle;
  logic [1:0]  res_code;
  logic [31:0] ctrl_out;
  logic [2:0]  int_mask;
  logic [7:0]  bus_pid;
  logic [6:0]  bus_dev;
  logic [3:0]  bus_ep;
  logic [10:0] bus_len;
  logic        bus_rsp_valid = 1'b0, bus_cpl_valid = 1'b0;
  logic [2:0]  bus_rsp_kind = '0, bus_cpl_kind = '0;
  logic [11:0] bus_rsp_len = '0, bus_cpl_len = '0;

  int checks = 0, failures = 0;

  // observation of the last run
  logic        o_req;
  logic [7:0]  o_pid;
  logic [6:0]  o_dev;
  logic [3:0]  o_ep;
  logic        o_tog;
  logic [10:0] o_len;
  logic [1:0]  o_code;
  logic [31:0] o_ctrl;
  logic [2:0]  o_mask;
  logic        o_perr, o_out;

  always #10 clk = ~clk;

  xd_engine uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tok(input logic [7:0] pid, input logic [6:0] dev,
                                      input logic [3:0] ep, input logic [10:0] lim);
    return {lim, 1'b0, 1'b1, ep, dev, pid};
  endfunction

  task automatic run(input logic [31:0] c, input logic [31:0] t, input logic rs,
                     input logic [2:0] kind, input logic [11:0] len);
    o_req = 1'b0;
    @(negedge clk);
    start = 1'b1; resume = rs; ctrl_in = c; token_in = t;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (done) begin
        o_code = res_code; o_ctrl = ctrl_out; o_mask = int_mask;
        o_perr = hc_perr;  o_out = outstanding;
        break;
      end
      bus_rsp_valid = 1'b0;
      if (bus_req) begin
        o_req = 1'b1; o_pid = bus_pid; o_dev = bus_dev; o_ep = bus_ep;
        o_tog = bus_toggle; o_len = bus_len;
        bus_rsp_valid = 1'b1; bus_rsp_kind = kind; bus_rsp_len = len;
      end
      @(negedge clk);
    end
    bus_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R14 reset ready", {31'd0, ready}, 32'd1);
    check("R14 reset done", {31'd0, done}, 32'd0);
    check("R12 reset outstanding", {31'd0, outstanding}, 32'd0);
    check("R14 reset bus_req", {31'd0, bus_req}, 32'd0);
  endtask

  task automatic t_in_short;
    run(32'h388807FF, tok(8'h69, 7'd5, 4'd2, 11'd63), 1'b0, 3'd0, 12'd10);
    check("R1 pid", {24'd0, o_pid}, 32'h69);
    check("R1 dev", {25'd0, o_dev}, 32'd5);
    check("R1 ep", {28'd0, o_ep}, 32'd2);
    check("R1 toggle", {31'd0, o_tog}, 32'd1);
    check("R1 limit", {21'd0, o_len}, 32'd64);
    check("R5 code", {30'd0, o_code}, 32'd0);
    check("R5 ctrl", o_ctrl, 32'h38000009);
    check("R7 mask", {29'd0, o_mask}, 32'b010);
  endtask

  task automatic t_babble;
    run(32'h18800000, tok(8'h69, 7'd1, 4'd0, 11'd7), 1'b0, 3'd0, 12'd20);
    check("R6 code", {30'd0, o_code}, 32'd1);
    check("R6 ctrl", o_ctrl, 32'h18500000);
  endtask

  task automatic t_out_zero;
    run(32'h01800000, tok(8'hE1, 7'd3, 4'd1, 11'h7FF), 1'b0, 3'd0, 12'd99);
    check("R1 zero limit", {21'd0, o_len}, 32'd0);
    check("R5 out ctrl", o_ctrl, 32'h010007FF);
    check("R2 mask", {29'd0, o_mask}, 32'b001);
    run(32'h20800000, tok(8'h2D, 7'd3, 4'd0, 11'd7), 1'b0, 3'd0, 12'd0);
    check("R5 setup code", {30'd0, o_code}, 32'd0);
    check("R5 setup ctrl", o_ctrl, 32'h20000007);
    check("R7 no short for setup", {29'd0, o_mask}, 32'd0);
  endtask

  task automatic t_nak_stall;
    run(32'h18800000, tok(8'h69, 7'd2, 4'd1, 11'd7), 1'b0, 3'd1, 12'd0);
    check("R8 code", {30'd0, o_code}, 32'd1);
    check("R8 ctrl", o_ctrl, 32'h18880000);
    run(32'h18800000, tok(8'hE1, 7'd2, 4'd1, 11'd7), 1'b0, 3'd2, 12'd0);
    check("R9 code", {30'd0, o_code}, 32'd1);
    check("R9 ctrl", o_ctrl, 32'h18400000);
  endtask

  task automatic t_errors;
    run(32'h10800000, tok(8'hE1, 7'd4, 4'd0, 11'd7), 1'b0, 3'd3, 12'd0);
    check("R10 err 2->1 ctrl", o_ctrl, 32'h08840000);
    check("R10 err 2->1 mask", {29'd0, o_mask}, 32'd0);
    run(32'h08800000, tok(8'hE1, 7'd4, 4'd0, 11'd7), 1'b0, 3'd3, 12'd0);
    check("R10 err 1->0 ctrl", o_ctrl, 32'h00040000);
    check("R10 err 1->0 mask", {29'd0, o_mask}, 32'b100);
    run(32'h00800000, tok(8'hE1, 7'd4, 4'd0, 11'd7), 1'b0, 3'd3, 12'd0);
    check("R10 err 0 ctrl", o_ctrl, 32'h00840000);
    check("R10 err 0 code", {30'd0, o_code}, 32'd1);
  endtask

  task automatic t_inactive_fatal;
    run(32'h01000000, tok(8'h69, 7'd1, 4'd1, 11'd7), 1'b0, 3'd0, 12'd1);
    check("R3 no request", {31'd0, o_req}, 32'd0);
    check("R3 code", {30'd0, o_code}, 32'd1);
    check("R3 ctrl", o_ctrl, 32'h01000000);
    check("R2 inactive mask", {29'd0, o_mask}, 32'b001);
    run(32'h01800000, tok(8'hA5, 7'd1, 4'd1, 11'd7), 1'b0, 3'd0, 12'd1);
    check("R4 no request", {31'd0, o_req}, 32'd0);
    check("R4 code", {30'd0, o_code}, 32'd3);
    check("R4 perr", {31'd0, o_perr}, 32'd1);
    check("R4 ctrl", o_ctrl, 32'h01800000);
    check("R2 fatal mask", {29'd0, o_mask}, 32'b001);
  endtask

  task automatic t_deferred;
    run(32'h01800000, tok(8'h69, 7'd9, 4'd1, 11'd15), 1'b0, 3'd4, 12'd0);
    check("R11 code", {30'd0, o_code}, 32'd2);
    check("R11 ctrl", o_ctrl, 32'h01800000);
    check("R11 outstanding", {31'd0, o_out}, 32'd1);
    run(32'h00800000, tok(8'hE1, 7'd6, 4'd3, 11'd7), 1'b0, 3'd0, 12'd0);
    check("R12 no request", {31'd0, o_req}, 32'd0);
    check("R12 code", {30'd0, o_code}, 32'd2);
    check("R12 ctrl", o_ctrl, 32'h00800000);
    run(32'h01800000, tok(8'h69, 7'd9, 4'd1, 11'd15), 1'b1, 3'd0, 12'd0);
    check("R13 early resume code", {30'd0, o_code}, 32'd2);
    check("R13 early resume no request", {31'd0, o_req}, 32'd0);
    @(negedge clk);
    bus_cpl_valid = 1'b1; bus_cpl_kind = 3'd0; bus_cpl_len = 12'd4;
    @(negedge clk);
    bus_cpl_valid = 1'b0;
    run(32'h01800000, tok(8'h69, 7'd9, 4'd1, 11'd15), 1'b1, 3'd0, 12'd0);
    check("R13 resume no request", {31'd0, o_req}, 32'd0);
    check("R13 resume code", {30'd0, o_code}, 32'd0);
    check("R13 resume ctrl", o_ctrl, 32'h01000003);
    @(negedge clk);
    check("R13 outstanding cleared", {31'd0, outstanding}, 32'd0);
    check("R14 result held", o_ctrl, ctrl_out);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_in_short;
    t_babble;
    t_out_zero;
    t_nak_stall;
    t_errors;
    t_inactive_fatal;
    t_deferred;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule